// File: doc/BRIEF.md
# Linear and Circular Address Generator

This block forms the byte address that a load or store sends to data memory. Each request carries a base pointer value, the pointer's identity (register side and index), an addressing mode, a displacement, an access size and the current addressing-mode control word. The displacement can come from a register or from a 5-bit unsigned constant. It is scaled by the access size and then added to or subtracted from the pointer. Offset modes only form an address. Pre and post modes also return the modified pointer with a write-back strobe, so that the register file can store it.

Circular addressing is allowed only for pointer indices 4 to 7 on either register side. For each such pointer, the control word holds a 2-bit field that selects linear addressing or one of two shared block-size exponents. When a pointer is circular, only the address bits below the block boundary take the modular sum. The bits above the boundary are kept from the pointer. Results appear one clock after the request.

Top module: `agu_addr_gen`

## Requirements
- R1: Mode code 0 gives address = pointer + scaled displacement, and mode code 1 gives pointer − scaled displacement. Neither raises the write-back strobe. Codes 6 and 7 behave like code 0.
- R2: Mode codes 2 (pre-increment) and 3 (pre-decrement) output the modified pointer as the address. They raise the write-back strobe, and the write-back value equals that address.
- R3: Mode codes 4 (post-increment) and 5 (post-decrement) output the unmodified pointer as the address. They raise the write-back strobe with the modified pointer as the write-back value.
- R4: The displacement is the 32-bit register operand when the select input is 1, and the zero-extended 5-bit constant when it is 0. It is shifted left by the size code (0 byte ×1, 1 halfword ×2, 2 word ×4, 3 doubleword ×8), and the result is truncated to 32 bits.
- R5: Pointer indices outside 4..7 always use linear arithmetic, whatever the control word holds.
- R6: In the control word, bits [1:0],[3:2],[5:4],[7:6] are the mode fields of side-A pointers 4..7, and bits [9:8]..[15:14] are those of side-B pointers 4..7. Field value 00 or 11 means linear. Value 01 uses the block exponent in bits [20:16], and value 10 uses the one in bits [25:21].
- R7: In circular mode with exponent N, the block is 2^(N+1) bytes. Address bits N+1 and above come from the pointer, and bits below take the sum or difference modulo the block size. N=31 therefore behaves as linear.
- R8: Linear arithmetic wraps modulo 2^32.
- R9: A request accepted on a clock edge yields a valid result after that edge. With no request the valid output and the write-back strobe are low, and after reset both are low and the address is zero.
- R10: Each result carries the side and index of the pointer in the request that produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code (see R1–R3) |
| req_side | input | 1 | Pointer register side, 0 = A, 1 = B |
| req_idx | input | 4 | Pointer register index within the side |
| req_ptr | input | 32 | Current pointer value |
| req_disp_sel | input | 1 | 1 = register displacement, 0 = constant |
| req_disp_reg | input | 32 | Register displacement operand |
| req_disp_imm | input | 5 | Unsigned constant displacement |
| req_size | input | 2 | Access size code |
| amr | input | 32 | Addressing-mode control word |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Effective byte address |
| out_wb_en | output | 1 | Pointer write-back strobe |
| out_wb_value | output | 32 | Modified pointer value |
| out_wb_side | output | 1 | Side of pointer to write back |
| out_wb_idx | output | 4 | Index of pointer to write back |

## Verification
Two functions can fall in the same cycle: a post-modify write-back and a circular wrap. In that case the address must still be the old pointer, while the write-back value folds across the buffer boundary. The bench provokes this with a post-decrement on a circular side-B pointer whose step carries it below the block base. It also sends requests back to back so that the scoreboard sees a circular result followed at once by a linear one. A reference model in the bench, built from the requirements, computes each expected address and write-back value. The monitor compares them in issue order, together with the strobe and the pointer identity.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [2:0] {
      AM_OFS_ADD  = 3'd0,
      AM_OFS_SUB  = 3'd1,
      AM_PRE_INC  = 3'd2,
      AM_PRE_DEC  = 3'd3,
      AM_POST_INC = 3'd4,
      AM_POST_DEC = 3'd5
   } agu_mode_e;

   // true when the mode returns a modified pointer
   function automatic logic mode_writes(input logic [2:0] m);
      return (m == AM_PRE_INC) || (m == AM_PRE_DEC) ||
             (m == AM_POST_INC) || (m == AM_POST_DEC);
   endfunction

   // true when the step is subtracted from the pointer
   function automatic logic mode_subtracts(input logic [2:0] m);
      return (m == AM_OFS_SUB) || (m == AM_PRE_DEC) || (m == AM_POST_DEC);
   endfunction

   // true when the memory sees the unmodified pointer
   function automatic logic mode_is_post(input logic [2:0] m);
      return (m == AM_POST_INC) || (m == AM_POST_DEC);
   endfunction

endpackage

// File: rtl/agu_disp_scale.sv
module agu_disp_scale #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 5
) (
   input  logic              use_reg,
   input  logic [ADDR_W-1:0] disp_reg,
   input  logic [IMM_W-1:0]  disp_imm,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] step
);
   logic [ADDR_W-1:0] raw;

   generate
      if (IMM_W > ADDR_W) begin : g_bad_imm
         $error("agu_disp_scale: IMM_W wider than ADDR_W");
      end
   endgenerate

   always_comb begin
      raw = use_reg ? disp_reg : ADDR_W'(disp_imm);
      unique case (size)
         2'd0:    step = raw;
         2'd1:    step = raw << 1;
         2'd2:    step = raw << 2;
         default: step = raw << 3;
      endcase
   end
endmodule

// File: rtl/agu_circ_sel.sv
module agu_circ_sel #(
   parameter int ADDR_W   = 32,
   parameter int AMR_W    = 32,
   parameter int IDX_W    = 4,
   parameter int CIRC_LO  = 4,
   parameter int CIRC_CNT = 4,
   parameter int BLK_W    = 5,
   parameter int NUM_BLK  = 2,
   parameter int BLK_POS  = 16
) (
   input  logic [AMR_W-1:0]  amr,
   input  logic              side,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] mask
);
   localparam int SLOTS    = 2 * CIRC_CNT;
   localparam int FLD_BITS = 2 * SLOTS;
   localparam int USED     = BLK_POS + NUM_BLK * BLK_W;
   localparam int LIM_W    = BLK_W + 1;

   logic [1:0]       fld    [SLOTS];
   logic [BLK_W-1:0] nfield [NUM_BLK];
   logic             in_range;
   logic             circ;
   logic [1:0]       sel;
   logic [BLK_W-1:0] nsel;
   logic [LIM_W-1:0] lim;

   generate
      if (FLD_BITS > BLK_POS) begin : g_bad_layout
         $error("agu_circ_sel: mode fields overlap block-size fields");
      end
      if (USED > AMR_W) begin : g_bad_amr
         $error("agu_circ_sel: control word too narrow");
      end
      if (NUM_BLK < 1 || NUM_BLK > 3) begin : g_bad_blk
         $error("agu_circ_sel: NUM_BLK must be 1..3");
      end
      for (genvar k = 0; k < SLOTS; k++) begin : g_fld
         assign fld[k] = amr[2*k +: 2];
      end
      for (genvar b = 0; b < NUM_BLK; b++) begin : g_nf
         assign nfield[b] = amr[BLK_POS + b*BLK_W +: BLK_W];
      end
      if (AMR_W > USED) begin : g_hi
         logic unused_amr_hi;
         assign unused_amr_hi = ^amr[AMR_W-1:USED];
      end
      if (BLK_POS > FLD_BITS) begin : g_gap
         logic unused_amr_gap;
         assign unused_amr_gap = ^amr[BLK_POS-1:FLD_BITS];
      end
   endgenerate

   always_comb begin
      in_range = (int'(idx) >= CIRC_LO) && (int'(idx) < CIRC_LO + CIRC_CNT);
      sel = 2'b00;
      for (int k = 0; k < SLOTS; k++) begin
         if (in_range && (int'(side) * CIRC_CNT + int'(idx) - CIRC_LO == k))
            sel = fld[k];
      end
      circ = (sel != 2'b00) && (int'(sel) <= NUM_BLK);
      nsel = '0;
      for (int b = 0; b < NUM_BLK; b++) begin
         if (int'(sel) == b + 1) nsel = nfield[b];
      end
      lim = LIM_W'(nsel) + LIM_W'(1);
   end

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
         assign mask[i] = !circ || (int'(lim) > i);
      end
   endgenerate
endmodule

// File: rtl/agu_modify.sv
module agu_modify #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] step,
   input  logic              sub,
   input  logic [ADDR_W-1:0] mask,
   output logic [ADDR_W-1:0] modified
);
   logic [ADDR_W-1:0] sum;

   always_comb begin
      sum      = sub ? (ptr - step) : (ptr + step);
      modified = (ptr & ~mask) | (sum & mask);
   end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
   import agu_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int AMR_W         = 32,
   parameter int REGS_PER_SIDE = 16,
   parameter int CIRC_LO       = 4,
   parameter int CIRC_CNT      = 4,
   parameter int BLK_W         = 5,
   parameter int NUM_BLK       = 2,
   parameter int BLK_POS       = 16,
   parameter int IMM_W         = 5,
   localparam int IDX_W        = $clog2(REGS_PER_SIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic              req_side,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [ADDR_W-1:0] req_ptr,
   input  logic              req_disp_sel,
   input  logic [ADDR_W-1:0] req_disp_reg,
   input  logic [IMM_W-1:0]  req_disp_imm,
   input  logic [1:0]        req_size,
   input  logic [AMR_W-1:0]  amr,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_wb_en,
   output logic [ADDR_W-1:0] out_wb_value,
   output logic              out_wb_side,
   output logic [IDX_W-1:0]  out_wb_idx
);
   generate
      if (CIRC_LO + CIRC_CNT > REGS_PER_SIDE) begin : g_bad_range
         $error("agu_addr_gen: circular pointer range exceeds register count");
      end
      if (ADDR_W > (1 << BLK_W)) begin : g_bad_blkw
         $error("agu_addr_gen: block exponent cannot span the address");
      end
   endgenerate

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] modified;
   logic [ADDR_W-1:0] eff_addr;

   agu_disp_scale #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_scale (
      .use_reg  (req_disp_sel),
      .disp_reg (req_disp_reg),
      .disp_imm (req_disp_imm),
      .size     (req_size),
      .step     (step)
   );

   agu_circ_sel #(
      .ADDR_W(ADDR_W), .AMR_W(AMR_W), .IDX_W(IDX_W), .CIRC_LO(CIRC_LO),
      .CIRC_CNT(CIRC_CNT), .BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .BLK_POS(BLK_POS)
   ) u_circ (
      .amr  (amr),
      .side (req_side),
      .idx  (req_idx),
      .mask (mask)
   );

   agu_modify #(.ADDR_W(ADDR_W)) u_mod (
      .ptr      (req_ptr),
      .step     (step),
      .sub      (mode_subtracts(req_mode)),
      .mask     (mask),
      .modified (modified)
   );

   assign eff_addr = mode_is_post(req_mode) ? req_ptr : modified;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_addr     <= '0;
         out_wb_en    <= 1'b0;
         out_wb_value <= '0;
         out_wb_side  <= 1'b0;
         out_wb_idx   <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_addr     <= eff_addr;
            out_wb_en    <= mode_writes(req_mode);
            out_wb_value <= modified;
            out_wb_side  <= req_side;
            out_wb_idx   <= req_idx;
         end else begin
            out_wb_en    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/agu_addr_gen_chk.sv
module agu_addr_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_mode,
   input logic              req_side,
   input logic [IDX_W-1:0]  req_idx,
   input logic [ADDR_W-1:0] req_ptr,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_wb_en,
   input logic [ADDR_W-1:0] out_wb_value,
   input logic              out_wb_side,
   input logic [IDX_W-1:0]  out_wb_idx
);
   assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && !out_wb_en));

   assert_offset_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == 3'd0 || req_mode == 3'd1 || req_mode > 3'd5))
      |=> !out_wb_en);

   assert_pre_addr_is_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == 3'd2 || req_mode == 3'd3))
      |=> (out_wb_en && out_addr == out_wb_value));

   assert_post_addr_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_mode == 3'd4 || req_mode == 3'd5))
      |=> (out_wb_en && out_addr == $past(req_ptr)));

   assert_identity_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_wb_side == $past(req_side) && out_wb_idx == $past(req_idx)));
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_agu_addr_gen.sv
`timescale 1ns/1ps
module sim_agu_addr_gen;
   typedef struct {
      logic [31:0] addr;
      logic        wb_en;
      logic [31:0] wb_val;
      logic        side;
      logic [3:0]  idx;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic        req_side = 1'b0;
   logic [3:0]  req_idx = '0;
   logic [31:0] req_ptr = '0;
   logic        req_disp_sel = 1'b0;
   logic [31:0] req_disp_reg = '0;
   logic [4:0]  req_disp_imm = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] amr = '0;
   logic        out_valid;
   logic [31:0] out_addr;
   logic        out_wb_en;
   logic [31:0] out_wb_value;
   logic        out_wb_side;
   logic [3:0]  out_wb_idx;

   int   checks = 0;
   int   errors = 0;
   bit   done = 0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   agu_addr_gen u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // reference model written from the requirements
   function automatic exp_t model(input logic [2:0] m, input logic s, input logic [3:0] ix,
                                  input logic [31:0] p, input logic dsel, input logic [31:0] dreg,
                                  input logic [4:0] dimm, input logic [1:0] sz,
                                  input logic [31:0] cw, input string tag);
      exp_t e;
      logic [31:0] st, sum, msk, modv;
      logic [1:0]  f;
      int          n;
      st  = (dsel ? dreg : {27'd0, dimm}) << sz;
      sum = (m == 3'd1 || m == 3'd3 || m == 3'd5) ? p - st : p + st;
      msk = 32'hFFFF_FFFF;
      if (ix >= 4 && ix <= 7) begin
         f = 2'((cw >> (2 * (int'(s) * 4 + int'(ix) - 4))) & 32'd3);
         n = -1;
         if (f == 2'd1) n = int'(cw[20:16]);
         if (f == 2'd2) n = int'(cw[25:21]);
         if (n >= 0 && n < 31) msk = (32'd1 << (n + 1)) - 32'd1;
      end
      modv     = (p & ~msk) | (sum & msk);
      e.wb_en  = (m >= 3'd2 && m <= 3'd5);
      e.addr   = (m == 3'd4 || m == 3'd5) ? p : modv;
      e.wb_val = modv;
      e.side   = s;
      e.idx    = ix;
      e.tag    = tag;
      return e;
   endfunction

   task automatic issue(input logic [2:0] m, input logic s, input logic [3:0] ix,
                        input logic [31:0] p, input logic dsel, input logic [31:0] dreg,
                        input logic [4:0] dimm, input logic [1:0] sz, input logic [31:0] cw,
                        input string tag);
      @(posedge clk); #1;
      req_valid = 1'b1; req_mode = m; req_side = s; req_idx = ix; req_ptr = p;
      req_disp_sel = dsel; req_disp_reg = dreg; req_disp_imm = dimm; req_size = sz; amr = cw;
      sb.push_back(model(m, s, ix, p, dsel, dreg, dimm, sz, cw, tag));
   endtask

   task automatic idle();
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   // monitor: pops the scoreboard as results appear
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               check("R9 unexpected result", 32'd1, 32'd0);
            end else begin
               e = sb.pop_front();
               check({e.tag, " addr"}, out_addr, e.addr);
               check({e.tag, " wb_en"}, {31'd0, out_wb_en}, {31'd0, e.wb_en});
               if (e.wb_en) check({e.tag, " wb_value"}, out_wb_value, e.wb_val);
               check({e.tag, " R10 identity"}, {27'd0, out_wb_side, out_wb_idx},
                     {27'd0, e.side, e.idx});
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset valid", {31'd0, out_valid}, 32'd0);
      check("R9 reset wb_en", {31'd0, out_wb_en}, 32'd0);
      check("R9 reset addr", out_addr, 32'd0);
      rst_n = 1'b1;

      // R1 offset add/sub, R4 constant and register displacement
      issue(3'd0, 1'b0, 4'd2, 32'h0000_1000, 1'b0, 32'd0, 5'd3, 2'd2, 32'd0, "R1 R4 ofs+ imm word");
      issue(3'd1, 1'b0, 4'd9, 32'h0000_1000, 1'b1, 32'd5, 5'd0, 2'd1, 32'd0, "R1 R4 ofs- reg half");
      issue(3'd7, 1'b1, 4'd0, 32'h0000_0040, 1'b0, 32'd0, 5'd1, 2'd0, 32'd0, "R1 code7 as ofs+");
      // R2 pre modes
      issue(3'd2, 1'b1, 4'd3, 32'h0000_2000, 1'b0, 32'd0, 5'd7, 2'd0, 32'd0, "R2 pre-inc byte");
      issue(3'd3, 1'b0, 4'd1, 32'h0000_2000, 1'b0, 32'd0, 5'd31, 2'd3, 32'd0, "R2 R4 pre-dec dword");
      // R3 post modes
      issue(3'd4, 1'b0, 4'd5, 32'h0000_3000, 1'b0, 32'd0, 5'd2, 2'd2, 32'd0, "R3 post-inc word");
      issue(3'd5, 1'b1, 4'd12, 32'h0000_3000, 1'b1, 32'd3, 5'd0, 2'd1, 32'd0, "R3 post-dec half");
      // R6 R7 circular, exponent 3 (16-byte block), A4 field 01
      issue(3'd2, 1'b0, 4'd4, 32'h0000_0100, 1'b0, 32'd0, 5'd9, 2'd2, 32'h0003_0001, "R7 R6 circ A4 pre-inc");
      // R6 same word but A5 field is 00: linear
      issue(3'd2, 1'b0, 4'd5, 32'h0000_0100, 1'b0, 32'd0, 5'd9, 2'd2, 32'h0003_0001, "R6 A5 field 00 linear");
      // R5 index outside 4..7 stays linear with every field set to 01
      issue(3'd2, 1'b0, 4'd3, 32'h0000_0100, 1'b0, 32'd0, 5'd9, 2'd2, 32'h0003_5555, "R5 A3 linear");
      issue(3'd2, 1'b1, 4'd8, 32'h0000_0100, 1'b0, 32'd0, 5'd9, 2'd2, 32'h0003_5555, "R5 B8 linear");
      // R6 R7 B7 field 10 uses second exponent N=4 (32 bytes); post-dec folds below base
      issue(3'd5, 1'b1, 4'd7, 32'h0000_2004, 1'b0, 32'd0, 5'd2, 2'd2, 32'h0080_8000, "R7 R3 circ B7 post-dec wrap");
      // R6 field 11 is linear
      issue(3'd4, 1'b1, 4'd6, 32'h0000_20F0, 1'b0, 32'd0, 5'd8, 2'd2, 32'h0003_3000, "R6 field 11 linear");
      // R7 exponent 31 equals linear
      issue(3'd2, 1'b0, 4'd6, 32'hFFFF_FFF0, 1'b0, 32'd0, 5'd4, 2'd3, 32'h001F_0010, "R7 N31 whole range");
      // R8 linear wrap
      issue(3'd2, 1'b0, 4'd0, 32'hFFFF_FFFC, 1'b0, 32'd0, 5'd1, 2'd3, 32'd0, "R8 linear wrap");
      // R4 register displacement truncated after scaling
      issue(3'd0, 1'b0, 4'd1, 32'h0000_0010, 1'b1, 32'h8000_0001, 5'd0, 2'd1, 32'd0, "R4 reg scale trunc");
      idle();
      @(negedge clk);
      @(negedge clk);
      check("R9 idle valid", {31'd0, out_valid}, 32'd0);
      check("R9 idle wb_en", {31'd0, out_wb_en}, 32'd0);

      // mixed stream with bubbles
      for (int i = 0; i < 60; i++) begin
         issue(3'($urandom_range(0, 7)), 1'($urandom), 4'($urandom), $urandom, 1'($urandom),
               $urandom, 5'($urandom), 2'($urandom), $urandom, "R7 R8 mixed stream");
         if (i % 7 == 3) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      check("R9 all results seen", sb.size(), 32'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule